// File: doc/BRIEF.md
# Handshake Character Sink

This block is the receiving end of a byte-wide parallel output link. A controller on another clock places a character on an 8-bit data bus and pulses a transfer-request line. The sink takes the character, drops its ready line, and holds ready low while it "prints". The print time is a countdown of a programmable number of sink clock cycles. When the countdown ends, ready rises again and the next character may be sent.

The sink stores one character only. The request line comes from a foreign clock domain, so it passes through a two-flop synchronizer and then a rising-edge detector. A request pulse of any length therefore yields exactly one acceptance. A request edge that arrives while the sink is busy is dropped and sets a sticky overrun flag. For checking, the sink shows the last fully printed character and an 8-bit count of completed prints.

Top module: `strobe_print_sink`

## Requirements
- R1: While reset (active low) is asserted, ready is 0. Ready rises on the first clock edge after reset is released, and it stays 1 while no character is held.
- R2: While reset is asserted, last_char is 0, printed_count is 0 and overrun is 0.
- R3: After xfer_req goes from 0 to 1, ready is still 1 after the first and second rising clock edges and is 0 after the third. The value on pdata at that third edge is the accepted character.
- R4: A request pulse yields exactly one acceptance, however many clock cycles it stays high. Ready does not fall again until a new 0-to-1 transition of xfer_req.
- R5: Ready stays 0 for exactly PRINT_CYCLES clock cycles after acceptance, then returns to 1.
- R6: On the edge where ready returns to 1, last_char takes the accepted character and printed_count increases by one, wrapping modulo 256. Neither output changes at any other time outside reset.
- R7: A request edge seen while ready is 0 causes no acceptance and no extra count. It sets overrun to 1, and overrun stays 1 until reset.
- R8: Changes on pdata after the accepting edge have no effect on the character reported in last_char.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sink clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdata | input | 8 | Parallel character from the controller |
| xfer_req | input | 1 | Transfer-request strobe, asynchronous to clk |
| ready | output | 1 | 1 when a new character can be accepted |
| last_char | output | 8 | Most recently completed character |
| printed_count | output | 8 | Count of completed characters, modulo 256 |
| overrun | output | 1 | Sticky flag: a request arrived while busy |

## Verification
The request is raised between clock edges, so the acceptance is due on the third rising edge that follows. The bench counts falling edges from the moment it raises xfer_req and expects ready high at counts 1 and 2 and low at count 3. Ready must then stay low through count PRINT_CYCLES+2 and be high at count PRINT_CYCLES+3. At that same count last_char, printed_count and overrun must hold their new values. All outputs are sampled on the falling edge, half a period clear of the edge that updates them, and three further idle cycles confirm that no late second acceptance occurs.

// File: rtl/strobe_print_sink.sv
module strobe_print_sink #(
  parameter int PRINT_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pdata,
  input  logic       xfer_req,
  output logic       ready,
  output logic [7:0] last_char,
  output logic [7:0] printed_count,
  output logic       overrun
);

  localparam int CW = (PRINT_CYCLES > 1) ? $clog2(PRINT_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PRINT_CYCLES - 1);

  logic          req_s1, req_s2, req_d;
  logic          req_rise;
  logic          busy;
  logic [CW-1:0] remain;
  logic [7:0]    held;

  assign req_rise = req_s2 & ~req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      req_d  <= 1'b0;
    end else begin
      req_s1 <= xfer_req;
      req_s2 <= req_s1;
      req_d  <= req_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready         <= 1'b0;
      busy          <= 1'b0;
      remain        <= '0;
      held          <= '0;
      last_char     <= '0;
      printed_count <= '0;
      overrun       <= 1'b0;
    end else begin
      if (busy) begin
        if (remain == '0) begin
          busy          <= 1'b0;
          ready         <= 1'b1;
          last_char     <= held;
          printed_count <= printed_count + 8'd1;
        end else begin
          remain <= remain - 1'b1;
        end
      end else if (ready && req_rise) begin
        busy   <= 1'b1;
        ready  <= 1'b0;
        held   <= pdata;
        remain <= LOAD;
      end else begin
        ready <= 1'b1;
      end
      if (req_rise && !ready)
        overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/strobe_print_sink_chk.sv
module strobe_print_sink_chk #(
  parameter int PRINT_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       req_rise,
  input logic [7:0] last_char,
  input logic [7:0] printed_count,
  input logic       overrun
);

  int low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_len <= 0;
    else if (!ready) low_len <= low_len + 1;
    else             low_len <= 0;
  end

  p_accept_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready && req_rise |=> !ready);

  p_print_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    printed_count != $past(printed_count) |-> low_len == PRINT_CYCLES);

  p_count_steps_by_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    printed_count != $past(printed_count) |-> printed_count == $past(printed_count) + 8'd1);

  p_count_with_ready_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    printed_count != $past(printed_count) |-> $rose(ready));

  p_last_stable_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && $past(!ready) |-> $stable(last_char));

  p_busy_edge_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && req_rise |=> overrun);

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

bind strobe_print_sink strobe_print_sink_chk #(.PRINT_CYCLES(PRINT_CYCLES)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ready(ready),
  .req_rise(req_rise),
  .last_char(last_char),
  .printed_count(printed_count),
  .overrun(overrun)
);

// File: tb/strobe_print_sink_test.sv
module strobe_print_sink_test;

  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pdata = 8'h00;
  logic       xfer_req = 1'b0;
  logic       ready;
  logic [7:0] last_char;
  logic [7:0] printed_count;
  logic       overrun;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_cnt = 8'd0;
  logic       exp_ov  = 1'b0;

  always #2 clk = ~clk;

  strobe_print_sink #(.PRINT_CYCLES(P)) uut (
    .clk(clk), .rst_n(rst_n), .pdata(pdata), .xfer_req(xfer_req),
    .ready(ready), .last_char(last_char), .printed_count(printed_count),
    .overrun(overrun)
  );

  function automatic logic [7:0] next_count(input logic [7:0] c);
    return c + 8'd1;
  endfunction

  function automatic int ready_expected(input int i);
    return (i >= 3 && i <= P + 2) ? 0 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [7:0] d, input int hold, input bit ovr, input bit wiggle);
    logic [7:0] prev_last;
    bit ready_bad;
    bit last_bad;
    int bad_ready_val;
    while (ready !== 1'b1) @(negedge clk);
    prev_last = last_char;
    pdata = d;
    xfer_req = 1'b1;
    ready_bad = 0;
    last_bad = 0;
    bad_ready_val = 0;
    for (int i = 1; i <= P + 3; i++) begin
      @(negedge clk);
      if (i == 2) chk(ready == 1'b1, "R3 ready still high after two edges", int'(ready), 1);
      if (i == 3) chk(ready == 1'b0, "R3 ready low after third edge", int'(ready), 0);
      if (i > 3 && i <= P + 2 && int'(ready) != ready_expected(i)) begin
        ready_bad = 1;
        bad_ready_val = int'(ready);
      end
      if (i <= P + 2 && last_char != prev_last) last_bad = 1;
      if (i == P + 3) begin
        chk(!ready_bad, "R5 ready held low during print", bad_ready_val, 0);
        chk(!last_bad, "R6 last_char stable during print", int'(last_char), int'(prev_last));
        chk(ready == 1'b1, "R5 ready back high after print", int'(ready), 1);
        chk(last_char == d, "R8 reported character", int'(last_char), int'(d));
        exp_cnt = next_count(exp_cnt);
        chk(printed_count == exp_cnt, "R6 printed count", int'(printed_count), int'(exp_cnt));
        if (ovr) exp_ov = 1'b1;
        chk(overrun == exp_ov, "R7 overrun flag", int'(overrun), int'(exp_ov));
      end
      if (i == hold) xfer_req = 1'b0;
      if (ovr && i == 5) xfer_req = 1'b1;
      if (ovr && i == 7) xfer_req = 1'b0;
      if (wiggle && i == 4) pdata = 8'($urandom);
    end
    if (xfer_req) begin
      repeat (2) @(negedge clk);
      xfer_req = 1'b0;
    end
    repeat (3) begin
      @(negedge clk);
      chk(ready == 1'b1 && printed_count == exp_cnt, "R4 no second acceptance",
          int'(printed_count), int'(exp_cnt));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 ready low in reset", int'(ready), 0);
    chk(last_char == 8'd0 && printed_count == 8'd0 && overrun == 1'b0,
        "R2 reset state", int'(printed_count), 0);
    rst_n = 1'b1;
    #0;
    chk(ready == 1'b0, "R1 ready low before first edge", int'(ready), 0);
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready high after first edge", int'(ready), 1);

    send(8'h00, 1, 0, 0);
    send(8'hFF, P + 5, 0, 1);
    send(8'h5A, 4, 0, 1);
    send(8'hA5, 2, 1, 0);
    send(8'h3C, 1, 0, 0);

    for (int n = 0; n < 256; n++) begin
      int h;
      bit ov;
      h  = ($urandom_range(0, 4) == 0) ? P + 5 : int'($urandom_range(1, 4));
      ov = (h <= 4) && ($urandom_range(0, 15) == 0);
      send(8'($urandom), h, ov, 1'($urandom_range(0, 1)));
    end
    chk(printed_count == exp_cnt, "R6 count wrapped modulo 256", int'(printed_count), int'(exp_cnt));

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R1 ready low in second reset", int'(ready), 0);
    chk(last_char == 8'd0 && printed_count == 8'd0 && overrun == 1'b0,
        "R2 second reset clears state", int'(overrun), 0);
    rst_n = 1'b1;
    exp_cnt = 8'd0;
    exp_ov = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready high after second reset", int'(ready), 1);
    send(8'h81, 3, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule